// File: doc/BRIEF.md
# Seven-Instruction Single-Cycle Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It supports a small integer subset: register add and subtract, OR with an immediate, word load, word store, branch when equal, and an absolute jump. A single main decoder turns the opcode and function fields into a set of datapath controls. One shared ALU handles arithmetic, the OR operation, address generation and the equality test for branches. The instruction memory, the data memory and the register file all sit inside the block.

Software images are placed in the instruction memory through a valid/ready write port while the core is held in reset. The port accepts a word on any cycle where both valid and ready are high, and ready is high only while reset is asserted. A write offered while the core runs is never accepted, so the sender must wait; nothing is queued. The current program counter is an output pin. A combinational debug read port on the register file lets a test environment inspect architectural state without disturbing execution.

Top module: `sc_cpu_top`

## Requirements
- R1: The instruction word is split as opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0]. Opcode 000000 with function 100000 writes rs+rt into rd, and with function 100010 it writes rs-rt into rd. Arithmetic wraps modulo 2^32.
- R2: Opcode 001101 writes rs OR {16'h0000, imm16} into rt, where imm16 is bits [15:0]. The immediate is zero-extended.
- R3: For opcodes 100011 (load) and 101011 (store), the byte address is rs plus the sign-extended imm16, and the word index is address bits [7:2]. A load writes that data word into rt. A store writes rt into that data word and leaves every register unchanged.
- R4: Opcode 000100 sets the next PC to PC+4+(sign-extended imm16 << 2) when rs equals rt. Otherwise the next PC is PC+4. No register is written.
- R5: Opcode 000010 sets the next PC to {(PC+4)[31:28], bits [25:0] of the instruction, 2'b00}. The PC stays word-aligned at all times.
- R6: Register 0 always reads as zero. Any instruction that names it as destination leaves it at zero.
- R7: An opcode outside the subset, or a function code other than the two listed in R1, changes no register and no memory word. The PC advances by 4.
- R8: While rst_n is low, the PC is 0 and every register and data word is 0.
- R9: A register or memory word written by one instruction holds the new value for the instruction that follows.
- R10: imem_wr_ready equals the inverse of rst_n. A word is stored at instruction index imem_wr_addr only when imem_wr_valid and imem_wr_ready are both high. An offer made while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the load port |
| imem_wr_valid | input | 1 | Load port: a word is offered |
| imem_wr_ready | output | 1 | Load port: a word can be taken (high only in reset) |
| imem_wr_addr | input | 6 | Load port: instruction word index |
| imem_wr_data | input | 32 | Load port: instruction word |
| pc_o | output | 32 | Address of the instruction now executing |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Contents of the selected register |

## Verification
The program includes two patterns that pull apart the extension choice. The first is an immediate of 0xFFFF, which zero-extends under OR. The second is a negative store offset, which must sign-extend. Carries and borrows are exercised by an add across the 16-bit boundary and a subtract that wraps negative. Branches are run both taken and not taken, and one backward-jumping countdown loop catches an offset or a target field taken from the wrong bits. Writes to register 0, an unknown opcode, an unknown function code and a load offered while running are mixed in. If any of these were acted on, the result shows up as a register value that the reference model does not have.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_write;
    logic    mem_write;
    logic    branch_eq;
    logic    jump;
    logic    sign_ext;
    alu_op_e alu_op;
  } ctl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.dst_is_rd = 1'b1;
          ctl.reg_write = 1'b1;
          ctl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctl.b_is_imm  = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = ALU_OR;
      end
      OPC_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
        ctl.sign_ext    = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
        ctl.sign_ext  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch_eq = 1'b1;
        ctl.alu_op    = ALU_SUB;
      end
      OPC_JMP: begin
        ctl.jump = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_dbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int   DEPTH          = 64,
  parameter int   W              = 32,
  parameter bit   CLEAR_ON_RESET = 1'b0,
  localparam int  AW             = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] words [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
          words[waddr] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
      end
    end
  endgenerate

  assign rdata = words[raddr];
endmodule

// File: rtl/sc_fetch.sv
module sc_fetch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         branch_eq,
  input  logic         alu_zero,
  input  logic         jump,
  input  logic [15:0]  imm16,
  input  logic [25:0]  target,
  output logic [W-1:0] pc
);
  logic [W-1:0] pc_seq;
  logic [W-1:0] br_off;
  logic [W-1:0] pc_next;

  assign pc_seq = pc + W'(4);
  assign br_off = {{(W-18){imm16[15]}}, imm16, 2'b00};

  always_comb begin
    if (jump)                       pc_next = {pc_seq[W-1:28], target, 2'b00};
    else if (branch_eq && alu_zero) pc_next = pc_seq + br_off;
    else                            pc_next = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end
endmodule

// File: rtl/sc_cpu_top.sv
module sc_cpu_top
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS),
  localparam int RAW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_wr_valid,
  output logic            imem_wr_ready,
  input  logic [IAW-1:0]  imem_wr_addr,
  input  logic [31:0]     imem_wr_data,
  output logic [31:0]     pc_o,
  input  logic [RAW-1:0]  dbg_raddr,
  output logic [31:0]     dbg_rdata
);
  ctl_t              ctl;
  logic [XLEN-1:0]   instr;
  logic [XLEN-1:0]   rs_val, rt_val;
  logic [XLEN-1:0]   imm_ext, alu_b, alu_y, dm_rdata, wb_data;
  logic              alu_zero;
  logic [RAW-1:0]    wb_addr;
  logic              rf_we, dm_we;

  assign imem_wr_ready = ~rst_n;

  sc_wordmem #(.DEPTH(IMEM_WORDS), .W(XLEN), .CLEAR_ON_RESET(1'b0)) u_imem (
    .clk(clk), .rst_n(rst_n),
    .we(imem_wr_valid & imem_wr_ready), .waddr(imem_wr_addr), .wdata(imem_wr_data),
    .raddr(pc_o[IAW+1:2]), .rdata(instr)
  );

  sc_ctrl u_ctrl (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign rf_we   = ctl.reg_write;
  assign dm_we   = ctl.mem_write;
  assign wb_addr = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(instr[25:21]), .rd_a(rs_val),
    .ra_b(instr[20:16]), .rd_b(rt_val),
    .ra_dbg(dbg_raddr), .rd_dbg(dbg_rdata),
    .we(rf_we), .wa(wb_addr), .wd(wb_data)
  );

  assign imm_ext = ctl.sign_ext ? {{16{instr[15]}}, instr[15:0]} : {16'h0000, instr[15:0]};
  assign alu_b   = ctl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  sc_wordmem #(.DEPTH(DMEM_WORDS), .W(XLEN), .CLEAR_ON_RESET(1'b1)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .we(dm_we), .waddr(alu_y[DAW+1:2]), .wdata(rt_val),
    .raddr(alu_y[DAW+1:2]), .rdata(dm_rdata)
  );

  assign wb_data = ctl.wb_from_mem ? dm_rdata : alu_y;

  sc_fetch #(.W(XLEN)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .branch_eq(ctl.branch_eq), .alu_zero(alu_zero), .jump(ctl.jump),
    .imm16(instr[15:0]), .target(instr[25:0]), .pc(pc_o)
  );
endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic        dm_we,
  input logic        ld_ready,
  input logic [4:0]  dbg_raddr,
  input logic [31:0] dbg_rdata
);
  logic [31:0] pc_plus4;
  logic        known;
  assign pc_plus4 = pc + 32'd4;
  assign known = (instr[31:26] == 6'b000000 && (instr[5:0] == 6'b100000 || instr[5:0] == 6'b100010))
              || instr[31:26] == 6'b001101 || instr[31:26] == 6'b100011
              || instr[31:26] == 6'b101011 || instr[31:26] == 6'b000100
              || instr[31:26] == 6'b000010;

  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'b000010) |=> pc == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00}); // R5

  AST_UNKNOWN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> pc == $past(pc_plus4)); // R7

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> !rf_we && !dm_we); // R7

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_raddr == 5'd0 |-> dbg_rdata == 32'd0); // R6

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && dm_we)); // R3

  AST_LOAD_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready); // R10
endmodule

bind sc_cpu_top sc_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc_o), .instr(instr),
  .rf_we(rf_we), .dm_we(dm_we), .ld_ready(imem_wr_ready),
  .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
);

// File: tb/sim_sc_cpu_top.sv
module sim_sc_cpu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 64;
  localparam int RUN_CYCLES = 70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_wr_valid = 1'b0;
  logic        imem_wr_ready;
  logic [5:0]  imem_wr_addr = '0;
  logic [31:0] imem_wr_data = '0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_raddr = '0;
  logic [31:0] dbg_rdata;

  int total = 0;
  int bad   = 0;

  logic [31:0] prog [NWORDS];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [int];
  logic [31:0] mpc;
  string       last_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cpu_top u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_wr_valid(imem_wr_valid), .imem_wr_ready(imem_wr_ready),
    .imem_wr_addr(imem_wr_addr), .imem_wr_data(imem_wr_data),
    .pc_o(pc_o), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input int slot);
    logic [31:0] a;
    a = slot * 4;
    return {6'b000010, a[27:2]};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic mwrite(input logic [4:0] a, input logic [31:0] v);
    if (a != 5'd0) mreg[a] = v;
    else last_tag = "R6";
  endtask

  task automatic model_step();
    logic [31:0] ins, nxt, sx, adr;
    ins = prog[(mpc >> 2) % NWORDS];
    sx  = {{16{ins[15]}}, ins[15:0]};
    nxt = mpc + 32'd4;
    case (ins[31:26])
      6'b000000: begin
        if (ins[5:0] == 6'b100000) begin
          last_tag = "R1"; mwrite(ins[15:11], mreg[ins[25:21]] + mreg[ins[20:16]]);
        end else if (ins[5:0] == 6'b100010) begin
          last_tag = "R1"; mwrite(ins[15:11], mreg[ins[25:21]] - mreg[ins[20:16]]);
        end else last_tag = "R7";
      end
      6'b001101: begin
        last_tag = "R2"; mwrite(ins[20:16], mreg[ins[25:21]] | {16'h0, ins[15:0]});
      end
      6'b100011: begin
        last_tag = "R3"; adr = mreg[ins[25:21]] + sx;
        mwrite(ins[20:16], mdm.exists(int'(adr >> 2)) ? mdm[int'(adr >> 2)] : 32'd0);
      end
      6'b101011: begin
        last_tag = "R3"; adr = mreg[ins[25:21]] + sx;
        mdm[int'(adr >> 2)] = mreg[ins[20:16]];
      end
      6'b000100: begin
        last_tag = "R4";
        if (mreg[ins[25:21]] == mreg[ins[20:16]]) nxt = nxt + {sx[29:0], 2'b00};
      end
      6'b000010: begin
        last_tag = "R5"; nxt = {nxt[31:28], ins[25:0], 2'b00};
      end
      default: last_tag = "R7";
    endcase
    mpc = nxt;
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'b001101, 5'd0, 5'd1, 16'h1234);
    prog[1]  = enc_i(6'b001101, 5'd0, 5'd2, 16'hFFFF);   // R2 zero-extend
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // R1, R9
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);       // R1 wraps negative
    prog[4]  = enc_i(6'b101011, 5'd0, 5'd3, 16'h0008);   // R3 store
    prog[5]  = enc_i(6'b001101, 5'd0, 5'd5, 16'h0020);
    prog[6]  = enc_i(6'b101011, 5'd5, 5'd4, 16'hFFFC);   // R3 negative offset
    prog[7]  = enc_i(6'b100011, 5'd0, 5'd6, 16'h0008);   // R3 load
    prog[8]  = enc_i(6'b100011, 5'd0, 5'd7, 16'h001C);
    prog[9]  = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);       // R6
    prog[10] = enc_i(6'b001101, 5'd0, 5'd0, 16'h0055);   // R6
    prog[11] = enc_i(6'b000100, 5'd6, 5'd3, 16'h0002);   // R4 taken
    prog[12] = enc_i(6'b001101, 5'd0, 5'd9, 16'h0BAD);
    prog[13] = enc_i(6'b001101, 5'd0, 5'd9, 16'h0BAD);
    prog[14] = enc_i(6'b000100, 5'd1, 5'd2, 16'h0005);   // R4 not taken
    prog[15] = enc_i(6'b111111, 5'd1, 5'd10, 16'h0011);  // R7 opcode
    prog[16] = enc_r(5'd1, 5'd2, 5'd11, 6'b100100);      // R7 funct
    prog[17] = enc_i(6'b001101, 5'd0, 5'd15, 16'h0777);
    prog[18] = enc_j(20);                                // R5
    prog[19] = enc_i(6'b001101, 5'd0, 5'd11, 16'h0BAD);
    prog[20] = enc_i(6'b001101, 5'd0, 5'd13, 16'h0001);
    prog[21] = enc_i(6'b001101, 5'd0, 5'd14, 16'h0003);
    prog[22] = enc_r(5'd14, 5'd13, 5'd14, 6'b100010);
    prog[23] = enc_i(6'b000100, 5'd14, 5'd0, 16'h0001);
    prog[24] = enc_j(22);                                // R5 backward
    prog[25] = enc_r(5'd14, 5'd1, 5'd16, 6'b100000);
    prog[26] = enc_j(26);
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    last_tag = "R8";

    // load phase, core held in reset
    for (int i = 0; i < NWORDS; i++) begin
      @(negedge clk);
      if (i == 0) check("R10", "ready in reset", {31'd0, imem_wr_ready}, 32'd1);
      imem_wr_valid = 1'b1;
      imem_wr_addr  = 6'(i);
      imem_wr_data  = prog[i];
    end
    @(negedge clk);
    imem_wr_valid = 1'b0;

    // reset state
    check("R8", "pc in reset", pc_o, 32'd0);
    for (int r = 0; r < 32; r++) begin
      dbg_raddr = 5'(r);
      #1;
      check("R8", "reg in reset", dbg_rdata, 32'd0);
    end
    dbg_raddr = 5'd0;

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", "ready when running", {31'd0, imem_wr_ready}, 32'd0);
    model_step();

    for (int c = 1; c <= RUN_CYCLES; c++) begin
      @(negedge clk);
      check(last_tag, "pc", pc_o, mpc);
      check(last_tag, "reg", dbg_rdata, mreg[dbg_raddr]);
      dbg_raddr = 5'(c % 32);
      if (c == 2) begin
        imem_wr_valid = 1'b1;
        imem_wr_addr  = 6'd17;
        imem_wr_data  = enc_i(6'b001101, 5'd0, 5'd15, 16'h0999);  // must be refused
      end else begin
        imem_wr_valid = 1'b0;
      end
      model_step();
    end

    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      dbg_raddr = 5'(r);
      #1;
      check(r == 15 ? "R10" : (r == 0 ? "R6" : "R9"), "final reg", dbg_rdata, mreg[r]);
    end
    check("R5", "final pc parked", pc_o, 32'd104);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule